// File: doc/BRIEF.md
# Framebuffer Scanout Address Generator

This block walks a framebuffer in memory and turns it into a stream of read burst requests, one line after another, for a display pipeline. Software supplies the byte address of the first pixel, the number of bytes to fetch per line, the byte step from one line start to the next, the number of lines less one, the burst length and a cap on outstanding read requests. A pulse on the frame start input copies all of these settings into the block, which then issues requests on a simple valid/acknowledge address channel.

Read data returns in request order, with a marker on the last beat of each burst. The data is collected in a small pixel FIFO, and the display side pulls one beat per active pixel. A request goes out only when it stays below the outstanding-request cap and the FIFO has room for every beat already requested plus the new burst. When the display asks for a pixel while the FIFO is empty, the block raises an underrun indication for that cycle.

Top module: `scanout_fetch`

## Requirements
- R1: After reset no request is pending (req_valid low), busy is low and the pixel FIFO is empty.
- R2: A frame_start seen while busy is low copies cfg_base, cfg_line_bytes, cfg_pitch, cfg_lines_m1, cfg_burst and cfg_max_outst and sets busy on the next cycle. Later changes to these inputs, and a frame_start while busy is high, have no effect on the frame in progress.
- R3: Line k (counting from 0) starts at base + k*pitch. Within a line, each burst starts at the line start plus 4 bytes (one 32-bit beat) times the number of beats already requested in that line.
- R4: Each request asks for the smaller of the burst length and the beats left in the line, so the last burst of a line is shortened. A cfg_burst of 0 or above 16 counts as 16.
- R5: A line holds cfg_line_bytes/4 beats (the remainder is dropped, and a line of at least one beat is fetched). A frame has cfg_lines_m1+1 lines. Once the last request is accepted, busy falls and no further request appears.
- R6: A request is raised only while the accepted requests not yet closed by a beat with rd_last are fewer than the cap. A cfg_max_outst of 0 or above the parameter limit counts as the limit.
- R7: A request is raised only if FIFO occupancy plus beats requested but not yet returned plus the new burst fits in the FIFO depth.
- R8: A request that is not acknowledged stays valid with an unchanged address and length.
- R9: When pix_req is high and the FIFO holds data, pix_valid is high in the same cycle and pix_data is the oldest beat. Beats leave in the order they returned.
- R10: When pix_req is high and the FIFO is empty, underrun is high, pix_valid is low and nothing is consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| frame_start | input | 1 | Begin a frame and capture settings |
| cfg_base | input | AW | Byte address of the first pixel |
| cfg_line_bytes | input | LW | Bytes fetched per line |
| cfg_pitch | input | AW | Byte step between line starts |
| cfg_lines_m1 | input | CW | Line count minus one |
| cfg_burst | input | BW | Burst length in beats |
| cfg_max_outst | input | OCW | Cap on outstanding requests |
| req_valid | output | 1 | Read request pending |
| req_addr | output | AW | Request byte address |
| req_beats | output | BW | Request length in beats |
| req_ack | input | 1 | Request accepted this cycle |
| rd_valid | input | 1 | Read data beat returned |
| rd_last | input | 1 | Last beat of a burst |
| rd_data | input | DW | Returned beat |
| pix_req | input | 1 | Display needs an active pixel |
| pix_valid | output | 1 | pix_data holds a pixel this cycle |
| pix_data | output | DW | Oldest FIFO beat |
| underrun | output | 1 | Pixel needed while FIFO empty |
| busy | output | 1 | Frame requests still to issue |

## Verification
The bench builds the block with a 16-entry FIFO, an outstanding cap limit of 4 and 32-bit beats, so a single 16-beat burst fills the FIFO and the room rule limits issue almost every cycle. It sweeps burst lengths 1, 3 and 16 as well as the out-of-range codes 0 and 20, line lengths of 1, 5, 16 and 17 beats (with a 22-byte length to drop a remainder), caps of 1, 2 and the default code, and frames of one and four lines. Three stall patterns on acknowledge, data return and pixel demand put the block in starved, bursty and backed-up states.

// File: rtl/scanout_fetch.sv
module scanout_fetch #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int LW = 16,
  parameter int CW = 12,
  parameter int MAX_BURST = 16,
  parameter int MAX_OUT = 4,
  parameter int FIFO_DEPTH = 32,
  localparam int BW = $clog2(MAX_BURST + 1),
  localparam int OCW = $clog2(MAX_OUT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_start,
  input  logic [AW-1:0] cfg_base,
  input  logic [LW-1:0] cfg_line_bytes,
  input  logic [AW-1:0] cfg_pitch,
  input  logic [CW-1:0] cfg_lines_m1,
  input  logic [BW-1:0] cfg_burst,
  input  logic [OCW-1:0] cfg_max_outst,
  output logic          req_valid,
  output logic [AW-1:0] req_addr,
  output logic [BW-1:0] req_beats,
  input  logic          req_ack,
  input  logic          rd_valid,
  input  logic          rd_last,
  input  logic [DW-1:0] rd_data,
  input  logic          pix_req,
  output logic          pix_valid,
  output logic [DW-1:0] pix_data,
  output logic          underrun,
  output logic          busy
);
  localparam int BSH = $clog2(DW / 8);
  localparam int LBW = LW - BSH;
  localparam int FCW = $clog2(FIFO_DEPTH + 1);
  localparam int PW  = $clog2(FIFO_DEPTH);
  localparam int SW  = FCW + 2;

  logic           active;
  logic [AW-1:0]  line_addr, pitch_q;
  logic [LBW-1:0] lbeats_q, off;
  logic [CW-1:0]  lines_q, line_idx;
  logic [BW-1:0]  burst_q;
  logic [OCW-1:0] maxo_q, outst;
  logic [FCW-1:0] inflight, fcount;
  logic [PW-1:0]  wp, rp;
  logic [DW-1:0]  mem [FIFO_DEPTH];

  wire [LBW-1:0] rem = lbeats_q - off;
  wire [BW-1:0]  nb = (rem > LBW'(burst_q)) ? burst_q : BW'(rem);
  wire [SW-1:0]  need = SW'(fcount) + SW'(inflight) + SW'(nb);
  wire           room = need <= SW'(FIFO_DEPTH);
  wire           fire = req_valid & req_ack;
  wire           line_end = (off + LBW'(nb)) == lbeats_q;
  wire           take = frame_start & ~active;
  wire [LBW-1:0] cfg_beats = cfg_line_bytes[LW-1:BSH];
  wire [BW-1:0]  eff_burst = (cfg_burst == '0 || cfg_burst > BW'(MAX_BURST)) ? BW'(MAX_BURST) : cfg_burst;
  wire [OCW-1:0] eff_out = (cfg_max_outst == '0 || cfg_max_outst > OCW'(MAX_OUT)) ? OCW'(MAX_OUT) : cfg_max_outst;
  wire           push = rd_valid;
  wire           pop = pix_req && fcount != '0;
  wire           rd_done = rd_valid & rd_last;

  assign req_valid = active && (outst < maxo_q) && room;
  assign req_addr  = line_addr + (AW'(off) << BSH);
  assign req_beats = nb;
  assign busy      = active;
  assign pix_valid = pop;
  assign pix_data  = mem[rp];
  assign underrun  = pix_req && fcount == '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      line_addr <= '0;
      pitch_q   <= '0;
      lbeats_q  <= '0;
      lines_q   <= '0;
      line_idx  <= '0;
      off       <= '0;
      burst_q   <= BW'(1);
      maxo_q    <= OCW'(1);
    end else if (take) begin
      active    <= 1'b1;
      line_addr <= cfg_base;
      pitch_q   <= cfg_pitch;
      lbeats_q  <= (cfg_beats == '0) ? LBW'(1) : cfg_beats;
      lines_q   <= cfg_lines_m1;
      line_idx  <= '0;
      off       <= '0;
      burst_q   <= eff_burst;
      maxo_q    <= eff_out;
    end else if (fire) begin
      if (line_end) begin
        off       <= '0;
        line_addr <= line_addr + pitch_q;
        if (line_idx == lines_q) active <= 1'b0;
        else line_idx <= line_idx + CW'(1);
      end else begin
        off <= off + LBW'(nb);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outst    <= '0;
      inflight <= '0;
    end else begin
      outst    <= outst + OCW'(fire) - OCW'(rd_done);
      inflight <= inflight + (fire ? FCW'(nb) : FCW'(0)) - FCW'(push);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp     <= '0;
      rp     <= '0;
      fcount <= '0;
    end else begin
      if (push) wp <= (wp == PW'(FIFO_DEPTH - 1)) ? '0 : wp + PW'(1);
      if (pop)  rp <= (rp == PW'(FIFO_DEPTH - 1)) ? '0 : rp + PW'(1);
      fcount <= fcount + FCW'(push) - FCW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= rd_data;
  end

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ack |=> req_valid && $stable(req_addr) && $stable(req_beats));

  p_burst_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_beats != '0 && req_beats <= burst_q);

  p_outst_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> outst <= maxo_q);

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (SW'(fcount) + SW'(inflight)) <= SW'(FIFO_DEPTH));

  p_pix_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> !pix_valid);
endmodule

// File: tb/sim_scanout_fetch.sv
`timescale 1ns/1ps
module sim_scanout_fetch;
  localparam int DEPTH = 16;
  localparam int MOUT = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_start = 1'b0;
  logic [31:0] cfg_base = '0, cfg_pitch = '0;
  logic [15:0] cfg_line_bytes = '0;
  logic [11:0] cfg_lines_m1 = '0;
  logic [4:0]  cfg_burst = '0;
  logic [2:0]  cfg_max_outst = '0;
  logic req_valid, req_ack, rd_valid, rd_last, pix_req, pix_valid, underrun, busy;
  logic [31:0] req_addr, rd_data, pix_data;
  logic [4:0]  req_beats;

  always #2.5 clk = ~clk;

  scanout_fetch #(.FIFO_DEPTH(DEPTH), .MAX_OUT(MOUT)) u0 (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .cfg_base(cfg_base),
    .cfg_line_bytes(cfg_line_bytes), .cfg_pitch(cfg_pitch), .cfg_lines_m1(cfg_lines_m1),
    .cfg_burst(cfg_burst), .cfg_max_outst(cfg_max_outst), .req_valid(req_valid),
    .req_addr(req_addr), .req_beats(req_beats), .req_ack(req_ack), .rd_valid(rd_valid),
    .rd_last(rd_last), .rd_data(rd_data), .pix_req(pix_req), .pix_valid(pix_valid),
    .pix_data(pix_data), .underrun(underrun), .busy(busy));

  int errors = 0, checks = 0;
  bit go = 0;
  int cyc = 0, mode = 0;
  int f_base, f_pitch, f_beats, f_lines, f_burst, f_maxo;
  int rq_line, rq_off, req_seen, tot_req;
  int px_line, px_beat, pix_seen, tot_pix;
  int model_cnt = 0, outst_m = 0, inflight_m = 0;
  int qa [64];
  int qb [64];
  int qw = 0, qr = 0, ret_beat = 0;
  bit ret_prev = 0, pop_prev = 0, last_prev = 0, held_prev = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!go) begin
      req_ack = 0; rd_valid = 0; rd_last = 0; rd_data = '0; pix_req = 0;
    end else begin
      int eb, ea, ib;
      bit ackp, retp;
      cyc++;
      if (ret_prev) model_cnt++;
      if (pop_prev) model_cnt--;
      if (last_prev) outst_m--;
      ret_prev = 0; pop_prev = 0; last_prev = 0;
      ackp = (mode == 0) ? 1'b1 : (mode == 1) ? (cyc % 3 != 0) : (cyc % 2 == 0);
      retp = (mode == 1) ? (cyc % 5 != 1) : 1'b1;
      ib = inflight_m;
      if (held_prev) chk(req_valid == 1'b1, "R8 request dropped before ack", req_valid, 1);
      held_prev = 0;
      req_ack = 0;
      eb = 0; ea = 0;
      if (req_valid) begin
        eb = (f_beats - rq_off < f_burst) ? f_beats - rq_off : f_burst;
        ea = f_base + rq_line * f_pitch + rq_off * 4;
        if (req_seen >= tot_req) chk(0, "R5 request after frame end", req_seen, tot_req);
        else begin
          chk(req_addr == ea, "R3 request address", req_addr, ea);
          chk(req_beats == eb, "R4 request beats", req_beats, eb);
          chk(outst_m < f_maxo, "R6 outstanding cap", outst_m, f_maxo);
          chk(model_cnt + ib + eb <= DEPTH, "R7 fifo room", model_cnt + ib + eb, DEPTH);
        end
        if (ackp) req_ack = 1; else held_prev = 1;
      end
      if (qw != qr && retp) begin
        rd_valid = 1;
        rd_data = qa[qr % 64] + ret_beat * 4;
        rd_last = (ret_beat == qb[qr % 64] - 1);
        ret_beat++;
        inflight_m--;
        ret_prev = 1;
        if (rd_last) begin qr++; ret_beat = 0; last_prev = 1; end
      end else begin
        rd_valid = 0; rd_last = 0;
      end
      if (req_ack && req_seen < tot_req) begin
        qa[qw % 64] = ea; qb[qw % 64] = eb; qw++;
        outst_m++; inflight_m += eb; req_seen++;
        rq_off += eb;
        if (rq_off == f_beats) begin rq_off = 0; rq_line++; end
      end
      pix_req = (mode == 0) ? 1'b1 : (mode == 1) ? cyc[0] : (cyc % 4 == 0);
      #1;
      chk(pix_valid == (pix_req && model_cnt > 0), "R9 pixel valid", pix_valid, pix_req && model_cnt > 0);
      chk(underrun == (pix_req && model_cnt == 0), "R10 underrun", underrun, pix_req && model_cnt == 0);
      if (pix_req && model_cnt > 0) begin
        int ep;
        ep = f_base + px_line * f_pitch + px_beat * 4;
        chk(pix_data == ep, "R9 pixel data order", pix_data, ep);
        pop_prev = 1; pix_seen++;
        px_beat++;
        if (px_beat == f_beats) begin px_beat = 0; px_line++; end
      end
    end
  end

  task automatic run_frame(input int base, input int lbytes, input int pitch,
                           input int lm1, input int burst, input int maxo);
    int t;
    f_base = base; f_pitch = pitch; f_lines = lm1 + 1;
    f_beats = (lbytes / 4 == 0) ? 1 : lbytes / 4;
    f_burst = (burst == 0 || burst > 16) ? 16 : burst;
    f_maxo = (maxo == 0 || maxo > MOUT) ? MOUT : maxo;
    tot_req = ((f_beats + f_burst - 1) / f_burst) * f_lines;
    tot_pix = f_beats * f_lines;
    rq_line = 0; rq_off = 0; req_seen = 0;
    px_line = 0; px_beat = 0; pix_seen = 0;
    cfg_base = base; cfg_line_bytes = lbytes[15:0]; cfg_pitch = pitch;
    cfg_lines_m1 = lm1[11:0]; cfg_burst = burst[4:0]; cfg_max_outst = maxo[2:0];
    frame_start = 1;
    @(negedge clk);
    chk(busy == 1'b1, "R2 busy after frame start", busy, 1);
    cfg_base = base ^ 32'h0000_7f00; cfg_line_bytes = 16'd200; cfg_pitch = 32'h40;
    cfg_lines_m1 = 12'd9; cfg_burst = 5'd2; cfg_max_outst = 3'd3;
    @(negedge clk);
    frame_start = 0;
    t = 0;
    while (pix_seen < tot_pix && t < 5000) begin @(negedge clk); t++; end
    if (t >= 5000) chk(0, "R5 frame watchdog", pix_seen, tot_pix);
    repeat (4) @(negedge clk);
    chk(busy == 1'b0, "R5 busy after frame", busy, 0);
    chk(req_seen == tot_req, "R5 request count", req_seen, tot_req);
    chk(outst_m == 0, "R6 all bursts closed", outst_m, 0);
  endtask

  initial begin
    int bl [5] = '{1, 3, 16, 0, 20};
    int ll [4] = '{4, 22, 64, 68};
    int ml [3] = '{1, 2, 0};
    int fr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_valid == 1'b0, "R1 no request after reset", req_valid, 0);
    chk(busy == 1'b0, "R1 idle after reset", busy, 0);
    chk(pix_valid == 1'b0, "R1 fifo empty after reset", pix_valid, 0);
    go = 1;
    for (int b = 0; b < 5; b++)
      for (int l = 0; l < 4; l++)
        for (int m = 0; m < 3; m++)
          for (int n = 0; n < 2; n++) begin
            mode = fr % 3;
            run_frame(32'h1000 + fr * 32'h40, ll[l], 256 + 8 * n, 3 * n, bl[b], ml[m]);
            fr++;
          end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(5.0 * 190000);
    errors++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule